// File: doc/BRIEF.md
# Fractional Word-to-Halfword Reducer

This block is one execute slot for a fixed-point signal-processing instruction. It takes a 32-bit instruction word and the values of two 64-bit source registers. It checks the word against one of two instruction encodings; a mode input picks which one. It then narrows the low 32-bit word of each source from Q31 to Q15. The narrowing adds half of the dropped LSB range, then clamps positive overflow to the largest Q15 value. The two halfwords are packed into the low 32 bits of a 64-bit result, and the upper 32 bits carry a copy of the sign of the upper halfword.

The result, a register write strobe with the destination index, an illegal-word flag and a unit-disabled flag all come out one clock after the word is accepted. A sticky overflow bit records that a committed operation clamped a value. The read indices of the two sources are decoded without a register stage, so that a register file can be addressed from them in the same cycle.

Top module: `wq_reducer`

## Requirements
- R1: A synchronous active-high `rst` clears `out_valid`, `wr_en`, `illegal`, `dsp_off` and `ovf_flag`. Reset is the only event that clears `ovf_flag`.
- R2: Each lane sign-extends its 32-bit word to 33 bits and adds 0x00008000. When no overflow occurs, the lane's Q15 value is bits 31..16 of that sum. For example, 0x12348000 gives 0x1235, 0x80000000 gives 0x8000 and 0xFFFF8000 gives 0x0000.
- R3: When bits 32 and 31 of the 33-bit sum differ, the lane gives 0x7FFF. Only positive inputs can reach this case. For example, 0x7FFF8000 gives 0x7FFF, and 0x7FFFFFFF also gives 0x7FFF.
- R4: `result` bits 31..16 hold the lane built from `rs_val`, and bits 15..0 hold the lane built from `rt_val`. Bits 63..32 each copy `result` bit 31.
- R5: With `enc_sel`=1 (compact), a word is legal when bits 31..26 = 000000, bit 10 = 0 and bits 9..0 = 0100101101. In that case `rt_idx` = bits 25..21, `rs_idx` = bits 20..16 and the destination is bits 15..11.
- R6: With `enc_sel`=0 (standard), a word is legal when bits 31..26 = 011111, bits 10..6 = 10101 and bits 5..0 = 010001. In that case `rs_idx` = bits 25..21, `rt_idx` = bits 20..16 and the destination is bits 15..11.
- R7: An accepted word that is not legal for the selected encoding raises `illegal` and keeps `wr_en` low. `ovf_flag` is left as it was, even when a lane would clamp.
- R8: A legal word accepted while `dsp_en`=0 raises `dsp_off` and keeps `wr_en` low, with `ovf_flag` left as it was. If the word is also illegal, only `illegal` is raised. At most one of `wr_en`, `illegal` and `dsp_off` is high at a time.
- R9: A legal, enabled word sets `ovf_flag` if either lane clamps. A later word that does not clamp leaves the flag set.
- R10: Outputs change one clock after the word is accepted (`in_valid` high at a rising edge). `out_valid` follows `in_valid` with one cycle of delay. When `out_valid` is low, `wr_en`, `illegal` and `dsp_off` are low. Back-to-back words are each processed.
- R11: Bits 63..32 of `rs_val` and `rt_val` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is presented this cycle |
| enc_sel | input | 1 | Encoding to decode: 1 compact, 0 standard |
| dsp_en | input | 1 | Signal-processing unit enabled |
| insn | input | 32 | Instruction word |
| rs_val | input | 64 | Value of the first source register |
| rt_val | input | 64 | Value of the second source register |
| rs_idx | output | 5 | First source index, combinational decode |
| rt_idx | output | 5 | Second source index, combinational decode |
| out_valid | output | 1 | Registered outputs belong to an accepted word |
| wr_en | output | 1 | Write `result` to register `wr_idx` |
| wr_idx | output | 5 | Destination register index |
| result | output | 64 | Packed, sign-extended Q15 pair |
| illegal | output | 1 | Accepted word did not match the selected encoding |
| dsp_off | output | 1 | Legal word refused because the unit is disabled |
| ovf_flag | output | 1 | Sticky clamp indicator of the control register |

## Verification
The source indices are combinational, so the bench checks them one time unit after it drives the word, in the same cycle. Every registered output, including the sticky flag, is due at the first rising edge after the word is accepted. The driver applies words at falling edges and queues the expected outcome, and the monitor compares one queued item at each falling edge where `out_valid` is high. Because the flag is modelled at queue time, each item carries the flag value that must appear together with that item's own result. An idle cycle is checked two falling edges after `in_valid` drops.

// File: rtl/wq_pkg.sv
package wq_pkg;

    localparam int REG_W  = 64;
    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
    localparam int IDX_W  = 5;
    localparam int INSN_W = 32;

    typedef enum logic {
        ENC_STANDARD = 1'b0,
        ENC_COMPACT  = 1'b1
    } enc_e;

    // fixed opcode fields of the two encodings
    localparam logic [5:0] STD_MAJOR = 6'b011111;
    localparam logic [4:0] STD_SUBOP = 5'b10101;
    localparam logic [5:0] STD_FUNC  = 6'b010001;
    localparam logic [5:0] CMP_MAJOR = 6'b000000;
    localparam logic [9:0] CMP_FUNC  = 10'b0100101101;

    typedef struct packed {
        logic             vld;
        logic             wr;
        logic [IDX_W-1:0] idx;
        logic [REG_W-1:0] res;
        logic             bad;
        logic             off;
        logic             ovf;
    } stage_t;

endpackage

// File: rtl/wq_decode.sv
module wq_decode
    import wq_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    input  logic              enc_sel,
    output logic              hit,
    output logic [IDX_W-1:0]  rs_idx,
    output logic [IDX_W-1:0]  rt_idx,
    output logic [IDX_W-1:0]  rd_idx
);

    enc_e mode;
    logic cmp_hit;
    logic std_hit;

    always_comb begin
        mode    = enc_e'(enc_sel);
        cmp_hit = (insn[31:26] == CMP_MAJOR) && !insn[10] && (insn[9:0] == CMP_FUNC);
        std_hit = (insn[31:26] == STD_MAJOR) && (insn[10:6] == STD_SUBOP)
                  && (insn[5:0] == STD_FUNC);
        rd_idx  = insn[15:11];
        if (mode == ENC_COMPACT) begin
            hit    = cmp_hit;
            rt_idx = insn[25:21];
            rs_idx = insn[20:16];
        end else begin
            hit    = std_hit;
            rs_idx = insn[25:21];
            rt_idx = insn[20:16];
        end
    end

endmodule

// File: rtl/wq_round_sat.sv
module wq_round_sat #(
    parameter int WORD_W = 32,
    parameter int HALF_W = 16
) (
    input  logic [WORD_W-1:0] word,
    output logic [HALF_W-1:0] half,
    output logic              sat
);

    localparam int DROP = WORD_W - HALF_W;
    localparam logic [WORD_W:0] RND = (WORD_W+1)'(1) << (DROP - 1);
    localparam logic [HALF_W-1:0] QMAX = {1'b0, {(HALF_W-1){1'b1}}};

    logic [WORD_W:0] sum;
    logic            unused_frac;

    always_comb begin
        sum         = {word[WORD_W-1], word} + RND;
        sat         = sum[WORD_W] ^ sum[WORD_W-1];
        half        = sat ? QMAX : sum[WORD_W-1:DROP];
        unused_frac = ^sum[DROP-1:0];
    end

endmodule

// File: rtl/wq_pack.sv
module wq_pack #(
    parameter int REG_W  = 64,
    parameter int HALF_W = 16
) (
    input  logic [HALF_W-1:0] hi_half,
    input  logic [HALF_W-1:0] lo_half,
    output logic [REG_W-1:0]  packed_val
);

    localparam int EXT_W = REG_W - 2*HALF_W;

    always_comb begin
        packed_val = {{EXT_W{hi_half[HALF_W-1]}}, hi_half, lo_half};
    end

endmodule

// File: rtl/wq_reducer.sv
module wq_reducer
    import wq_pkg::*;
#(
    parameter int REG_W  = wq_pkg::REG_W,
    parameter int WORD_W = wq_pkg::WORD_W,
    parameter int HALF_W = wq_pkg::HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              enc_sel,
    input  logic              dsp_en,
    input  logic [INSN_W-1:0] insn,
    input  logic [REG_W-1:0]  rs_val,
    input  logic [REG_W-1:0]  rt_val,
    output logic [IDX_W-1:0]  rs_idx,
    output logic [IDX_W-1:0]  rt_idx,
    output logic              out_valid,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [REG_W-1:0]  result,
    output logic              illegal,
    output logic              dsp_off,
    output logic              ovf_flag
);

    localparam int LANES = 2;   // lane 1 from rs, lane 0 from rt

    logic                          hit;
    logic [IDX_W-1:0]              rd_idx;
    logic [LANES-1:0][WORD_W-1:0]  lane_word;
    logic [LANES-1:0][HALF_W-1:0]  lane_half;
    logic [LANES-1:0]              lane_sat;
    logic [REG_W-1:0]              packed_val;
    logic                          unused_upper;
    stage_t                        stg_d;
    stage_t                        stg_q;

    wq_decode u_dec (
        .insn   (insn),
        .enc_sel(enc_sel),
        .hit    (hit),
        .rs_idx (rs_idx),
        .rt_idx (rt_idx),
        .rd_idx (rd_idx)
    );

    always_comb begin
        lane_word[1] = rs_val[WORD_W-1:0];
        lane_word[0] = rt_val[WORD_W-1:0];
        unused_upper = ^{rs_val[REG_W-1:WORD_W], rt_val[REG_W-1:WORD_W]};
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        wq_round_sat #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_cvt (
            .word(lane_word[g]),
            .half(lane_half[g]),
            .sat (lane_sat[g])
        );
    end

    wq_pack #(.REG_W(REG_W), .HALF_W(HALF_W)) u_pack (
        .hi_half   (lane_half[1]),
        .lo_half   (lane_half[0]),
        .packed_val(packed_val)
    );

    always_comb begin
        stg_d     = stg_q;
        stg_d.vld = in_valid;
        stg_d.wr  = in_valid && hit && dsp_en;
        stg_d.bad = in_valid && !hit;
        stg_d.off = in_valid && hit && !dsp_en;
        if (in_valid) begin
            stg_d.idx = rd_idx;
            stg_d.res = packed_val;
        end
        stg_d.ovf = stg_q.ovf || (stg_d.wr && (|lane_sat));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    always_comb begin
        out_valid = stg_q.vld;
        wr_en     = stg_q.wr;
        wr_idx    = stg_q.idx;
        result    = stg_q.res;
        illegal   = stg_q.bad;
        dsp_off   = stg_q.off;
        ovf_flag  = stg_q.ovf;
    end

endmodule

// File: rtl/wq_reducer_chk.sv
module wq_reducer_chk #(
    parameter int REG_W  = 64,
    parameter int HALF_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic             wr_en,
    input logic             illegal,
    input logic             dsp_off,
    input logic             ovf_flag,
    input logic [REG_W-1:0] result
);

    localparam int LOW_W = 2*HALF_W;
    localparam logic [HALF_W-1:0] QMAX = {1'b0, {(HALF_W-1){1'b1}}};

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && !ovf_flag && !wr_en)); // R1

    AST_VALID_LAGS_ONE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid))); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!wr_en && !illegal && !dsp_off)); // R10

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, illegal, dsp_off})); // R8

    AST_FLAG_STICKS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ovf_flag)) |-> ovf_flag); // R9

    AST_FLAG_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> wr_en); // R7

    AST_FLAG_SHOWS_CLAMP: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> (result[LOW_W-1:HALF_W] == QMAX || result[HALF_W-1:0] == QMAX)); // R3

    AST_UPPER_SIGN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (result[REG_W-1:LOW_W] == {(REG_W-LOW_W){result[LOW_W-1]}})); // R4

endmodule

bind wq_reducer wq_reducer_chk #(.REG_W(REG_W), .HALF_W(HALF_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .wr_en    (wr_en),
    .illegal  (illegal),
    .dsp_off  (dsp_off),
    .ovf_flag (ovf_flag),
    .result   (result)
);

// File: tb/tb_wq_reducer.sv
`timescale 1ns/1ps
module tb_wq_reducer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        enc_sel = 1'b0;
    logic        dsp_en = 1'b1;
    logic [31:0] insn = '0;
    logic [63:0] rs_val = '0;
    logic [63:0] rt_val = '0;
    logic [4:0]  rs_idx, rt_idx, wr_idx;
    logic        out_valid, wr_en, illegal, dsp_off, ovf_flag;
    logic [63:0] result;

    int checks = 0;
    int fails  = 0;
    logic ovf_m = 1'b0;

    typedef struct {
        logic        wr;
        logic [4:0]  idx;
        logic [63:0] res;
        logic        bad;
        logic        off;
        logic        ovf;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    wq_reducer dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .enc_sel(enc_sel), .dsp_en(dsp_en),
        .insn(insn), .rs_val(rs_val), .rt_val(rt_val), .rs_idx(rs_idx), .rt_idx(rt_idx),
        .out_valid(out_valid), .wr_en(wr_en), .wr_idx(wr_idx), .result(result),
        .illegal(illegal), .dsp_off(dsp_off), .ovf_flag(ovf_flag)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Q31 -> {clamped, Q15} from the stated rule
    function automatic logic [16:0] conv(input logic [31:0] w);
        logic [32:0] s;
        s = {w[31], w} + 33'h0_0000_8000;
        if (s[32] != s[31]) return {1'b1, 16'h7FFF};
        return {1'b0, s[31:16]};
    endfunction

    function automatic logic [31:0] enc_cmp(input logic [4:0] rd, input logic [4:0] rs, input logic [4:0] rt);
        return {6'b000000, rt, rs, rd, 1'b0, 10'b0100101101};
    endfunction

    function automatic logic [31:0] enc_std(input logic [4:0] rd, input logic [4:0] rs, input logic [4:0] rt);
        return {6'b011111, rs, rt, rd, 5'b10101, 6'b010001};
    endfunction

    task automatic send(input logic [31:0] w, input logic enc, input logic en, input logic legal,
                        input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd,
                        input logic [63:0] a, input logic [63:0] b, input string tag);
        exp_t e;
        logic [16:0] ha, hb;
        @(negedge clk);
        insn = w; enc_sel = enc; dsp_en = en; rs_val = a; rt_val = b; in_valid = 1'b1;
        ha = conv(a[31:0]);
        hb = conv(b[31:0]);
        e.wr  = legal && en;
        e.idx = rd;
        e.res = {{32{ha[15]}}, ha[15:0], hb[15:0]};
        e.bad = !legal;
        e.off = legal && !en;
        if (e.wr && (ha[16] || hb[16])) ovf_m = 1'b1;
        e.ovf = ovf_m;
        e.tag = tag;
        sb.push_back(e);
        if (legal) begin
            #1;
            check(rs_idx == rs && rt_idx == rt, {tag, " source index"},
                  {54'd0, rs_idx, rt_idx}, {54'd0, rs, rt});
        end
    endtask

    task automatic idle_check();
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check(!out_valid && !wr_en && !illegal && !dsp_off, "R10 idle outputs low",
              {60'd0, out_valid, wr_en, illegal, dsp_off}, 64'd0);
    endtask

    // monitor: compares one queued item per valid output
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10 unexpected out_valid", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(wr_en == e.wr && illegal == e.bad && dsp_off == e.off && ovf_flag == e.ovf,
                      {e.tag, " flags wr/bad/off/ovf"},
                      {60'd0, wr_en, illegal, dsp_off, ovf_flag}, {60'd0, e.wr, e.bad, e.off, e.ovf});
                check(result == e.res, {e.tag, " result"}, result, e.res);
                if (e.wr) check(wr_idx == e.idx, {e.tag, " destination"}, {59'd0, wr_idx}, {59'd0, e.idx});
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        // the reference model against the stated examples
        check(conv(32'h8000_0000) == 17'h0_8000, "R2 model negative", {47'd0, conv(32'h8000_0000)}, 64'h8000);
        check(conv(32'h7FFF_8000) == 17'h1_7FFF, "R3 model clamp", {47'd0, conv(32'h7FFF_8000)}, 64'h17FFF);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && !wr_en && !ovf_flag && !illegal && !dsp_off, "R1 reset state",
              {59'd0, out_valid, wr_en, ovf_flag, illegal, dsp_off}, 64'd0);

        // refused words with clamping inputs must leave the flag clear
        send(enc_cmp(5'd3, 5'd1, 5'd2) | 32'h0000_0400, 1'b1, 1'b1, 1'b0, 0, 0, 5'd3,
             64'h7FFF_8000, 64'h7FFF_FFFF, "R7 compact bit10 set");
        send(enc_std(5'd4, 5'd5, 5'd6), 1'b1, 1'b1, 1'b0, 0, 0, 5'd4,
             64'h7FFF_8000, 64'h0, "R7 encoding mismatch");
        send(enc_std(5'd7, 5'd8, 5'd9), 1'b0, 1'b0, 1'b1, 5'd8, 5'd9, 5'd7,
             64'h7FFF_FFFF, 64'h7FFF_8000, "R8 unit disabled");
        send(enc_cmp(5'd7, 5'd8, 5'd9) ^ 32'h0000_0001, 1'b1, 1'b0, 1'b0, 0, 0, 5'd7,
             64'h7FFF_FFFF, 64'h0, "R8 illegal wins over disabled");
        idle_check();

        // arithmetic and packing
        send(enc_cmp(5'd10, 5'd11, 5'd12), 1'b1, 1'b1, 1'b1, 5'd11, 5'd12, 5'd10,
             64'h1234_8000, 64'h0001_7FFF, "R5 R2 compact round");
        send(enc_std(5'd13, 5'd14, 5'd15), 1'b0, 1'b1, 1'b1, 5'd14, 5'd15, 5'd13,
             64'h8000_0000, 64'hFFFF_8000, "R6 R2 R4 negative sign fill");
        send(enc_std(5'd16, 5'd17, 5'd18), 1'b0, 1'b1, 1'b1, 5'd17, 5'd18, 5'd16,
             64'hDEAD_BEEF_0001_0000, 64'hFFFF_FFFF_0002_8000, "R11 upper bits ignored");
        send(enc_cmp(5'd19, 5'd20, 5'd21), 1'b1, 1'b1, 1'b1, 5'd20, 5'd21, 5'd19,
             64'h4000_0000, 64'h7FFF_8000, "R3 R9 rt lane clamps");
        send(enc_cmp(5'd22, 5'd23, 5'd24), 1'b1, 1'b1, 1'b1, 5'd23, 5'd24, 5'd22,
             64'h0000_1000, 64'h0000_0000, "R9 flag stays set");
        send(enc_std(5'd25, 5'd26, 5'd27), 1'b0, 1'b1, 1'b1, 5'd26, 5'd27, 5'd25,
             64'h7FFF_FFFF, 64'hFFFF_7FFF, "R3 rs lane clamps");
        idle_check();

        // back-to-back stream with varied words and both encodings
        for (int i = 1; i <= 24; i++) begin
            logic [31:0] a, b;
            logic [4:0] d, s, t;
            a = 32'h9E37_79B9 * i;
            b = 32'h7FFF_0000 + 32'h0000_1234 * i;
            d = 5'(i); s = 5'(i + 3); t = 5'(i + 9);
            if (i[0])
                send(enc_cmp(d, s, t), 1'b1, 1'b1, 1'b1, s, t, d, {32'hA5A5_0000, a}, {32'h0, b}, "R10 stream compact");
            else
                send(enc_std(d, s, t), 1'b0, (i % 6) != 0, 1'b1, s, t, d, {32'h0, a}, {32'h5A5A_0000, b}, "R10 stream standard");
        end
        idle_check();

        // reset clears the sticky flag
        @(negedge clk);
        rst = 1'b1;
        ovf_m = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!ovf_flag && !out_valid, "R1 reset clears flag", {62'd0, ovf_flag, out_valid}, 64'd0);
        send(enc_cmp(5'd1, 5'd2, 5'd3), 1'b1, 1'b1, 1'b1, 5'd2, 5'd3, 5'd1,
             64'h0000_7FFF, 64'hFFFF_FFFF, "R2 R9 after reset no clamp");
        idle_check();

        check(sb.size() == 0, "R10 all results delivered", 64'(sb.size()), 64'd0);
        summary();
        $finish;
    end

endmodule